// File: doc/BRIEF.md
# Fifteen-Bit Modular ALU

This block is the arithmetic and logic stage of a small 16-bit stack machine. Each cycle it takes a 5-bit operation code and two operand values that an earlier stage has already resolved, and on the next rising clock edge it presents a 16-bit result. With the result it gives a write-enable flag for the destination register and a flag that marks a remainder by zero.

Arithmetic wraps at 2^15, not at 2^16. The one-operand inverse flips only the low fifteen bits. Every arithmetic and inverse result therefore has bit 15 clear and stays inside the literal range of the machine. Comparisons return 0 or 1. Codes outside the ALU set give no write. The surrounding core uses this to leave its register file alone when the instruction is a branch, a stack operation or a memory operation.

Top module: `alu15_core`

## Requirements
- R1: Code 4 (equality) yields 1 when operand A equals operand B and 0 when they differ, with write-enable high.
- R2: Code 5 (greater-than) yields 1 when A is above B as unsigned 16-bit numbers and 0 otherwise, including when they are equal.
- R3: Code 9 (add) yields (A + B) mod 32768. The carry out of bit 14 and anything above it are discarded.
- R4: Code 10 (multiply) yields the full 32-bit product A*B reduced mod 32768.
- R5: Code 11 (remainder) yields A mod B for a nonzero B, with the zero-divide flag low.
- R6: Code 11 with B equal to 0 raises the zero-divide flag and yields 0 with write-enable high. The flag is low for every other operation.
- R7: Code 12 yields A AND B and code 13 yields A OR B, over all 16 bits.
- R8: Code 14 (inverse) yields the bitwise complement of A masked with 0x7FFF. Operand B has no effect on the result.
- R9: Any code other than 4, 5, 9, 10, 11, 12, 13 and 14 gives write-enable low, result 0 and the zero-divide flag low.
- R10: All outputs are registered. A result appears one clock edge after its inputs and holds between edges. A synchronous active-high reset clears the result and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 5 | Operation code |
| opnd_a | input | 16 | First operand value |
| opnd_b | input | 16 | Second operand value (unused by the inverse) |
| res_q | output | 16 | Registered result |
| wr_en_q | output | 1 | Registered destination write-enable |
| div_zero_q | output | 1 | Registered remainder-by-zero flag |

## Verification
A wrong selection in the output mux shows at the ports one edge after the inputs are applied, as a result from the wrong unit or a write-enable that does not match the code. This is why each check samples at the falling edge after exactly one rising edge. A missing 15-bit reduction shows up only in operands that carry past bit 14, so the directed cases use 0x7FFF+1, 0xFFFF+0xFFFF and 0xFFFF*0xFFFF. A signed comparison shows only when bit 15 differs, so the greater-than case uses 0x8000 against 0x7FFF. A remainder unit that does not guard the zero divisor shows on the same edge as a nonzero result or a low flag.

// File: rtl/alu15_pkg.sv
package alu15_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_EQ  = 5'd4,
    OP_GT  = 5'd5,
    OP_ADD = 5'd9,
    OP_MUL = 5'd10,
    OP_REM = 5'd11,
    OP_AND = 5'd12,
    OP_OR  = 5'd13,
    OP_INV = 5'd14
  } alu_op_e;
endpackage

// File: rtl/alu15_arith.sv
module alu15_arith #(
  parameter int DATA_W = 16,
  parameter int KEEP_W = 15
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] prod_o
);
  localparam int PAD_W = DATA_W - KEEP_W;

  logic [KEEP_W-1:0] sum_low;
  logic [KEEP_W-1:0] prod_low;

  // Truncation of the full-width sum and product keeps the low KEEP_W bits,
  // which is the reduction modulo 2^KEEP_W.
  assign sum_low  = KEEP_W'(a_i + b_i);
  assign prod_low = KEEP_W'(a_i * b_i);

  assign sum_o  = {{PAD_W{1'b0}}, sum_low};
  assign prod_o = {{PAD_W{1'b0}}, prod_low};
endmodule

// File: rtl/alu15_bitwise.sv
module alu15_bitwise #(
  parameter int DATA_W = 16,
  parameter int KEEP_W = 15
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] inv_o,
  output logic              eq_o,
  output logic              gt_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    if (i < KEEP_W) begin : g_keep
      assign inv_o[i] = ~a_i[i];
    end else begin : g_drop
      assign inv_o[i] = 1'b0;
    end
  end

  assign eq_o = (a_i == b_i);
  assign gt_o = (a_i > b_i);
endmodule

// File: rtl/alu15_rem.sv
module alu15_rem #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] rem_o,
  output logic              zero_div_o
);
  assign zero_div_o = (b_i == '0);
  assign rem_o      = zero_div_o ? '0 : (a_i % b_i);
endmodule

// File: rtl/alu15_core.sv
module alu15_core
  import alu15_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int KEEP_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] res_q,
  output logic              wr_en_q,
  output logic              div_zero_q
);
  logic [DATA_W-1:0] sum_w, prod_w, and_w, or_w, inv_w, rem_w;
  logic              eq_w, gt_w, zdiv_w;

  logic [DATA_W-1:0] res_d;
  logic              wr_en_d;
  logic              div_zero_d;

  alu15_arith #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_arith (
    .a_i(opnd_a), .b_i(opnd_b), .sum_o(sum_w), .prod_o(prod_w)
  );

  alu15_bitwise #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_bitwise (
    .a_i(opnd_a), .b_i(opnd_b), .and_o(and_w), .or_o(or_w),
    .inv_o(inv_w), .eq_o(eq_w), .gt_o(gt_w)
  );

  alu15_rem #(.DATA_W(DATA_W)) u_rem (
    .a_i(opnd_a), .b_i(opnd_b), .rem_o(rem_w), .zero_div_o(zdiv_w)
  );

  always_comb begin
    res_d      = '0;
    wr_en_d    = 1'b1;
    div_zero_d = 1'b0;
    case (op_code)
      OP_EQ:   res_d = DATA_W'(eq_w);
      OP_GT:   res_d = DATA_W'(gt_w);
      OP_ADD:  res_d = sum_w;
      OP_MUL:  res_d = prod_w;
      OP_REM: begin
        res_d      = rem_w;
        div_zero_d = zdiv_w;
      end
      OP_AND:  res_d = and_w;
      OP_OR:   res_d = or_w;
      OP_INV:  res_d = inv_w;
      default: wr_en_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q      <= '0;
      wr_en_q    <= 1'b0;
      div_zero_q <= 1'b0;
    end else begin
      res_q      <= res_d;
      wr_en_q    <= wr_en_d;
      div_zero_q <= div_zero_d;
    end
  end

  // R1 R2: comparison results are boolean
  assert_cmp_bool_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(op_code) == OP_EQ || $past(op_code) == OP_GT) |-> (res_q <= 16'd1 && wr_en_q));

  // R3 R4 R8: wrapped and inverted results stay in the 15-bit range
  assert_mod_range_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(op_code) == OP_ADD || $past(op_code) == OP_MUL || $past(op_code) == OP_INV)
      |-> (res_q[DATA_W-1:KEEP_W] == '0));

  // R5: remainder is below a nonzero divisor
  assert_rem_below_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(op_code) == OP_REM && $past(opnd_b) != '0) |-> (res_q < $past(opnd_b) && !div_zero_q));

  // R6: zero-divide flag only with a zero result and a write
  assert_div_zero_R6: assert property (@(posedge clk) disable iff (rst)
    div_zero_q |-> (res_q == '0 && wr_en_q && $past(op_code) == OP_REM));

  // R9: no write means nothing else is reported
  assert_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en_q |-> (res_q == '0 && !div_zero_q));

  // R10: outputs follow a reset one edge later as cleared
  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && !wr_en_q && !div_zero_q));
endmodule

// File: tb/alu15_core_tb.sv
module alu15_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_code = '0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [15:0] res_q;
  logic        wr_en_q;
  logic        div_zero_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu15_core u_dut (
    .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_q(res_q), .wr_en_q(wr_en_q), .div_zero_q(div_zero_q)
  );

  task automatic check(string req, logic [15:0] r, logic w, logic z,
                       logic [15:0] er, logic ew, logic ez);
    checks++;
    if (r !== er || w !== ew || z !== ez) begin
      errors++;
      $display("FAIL %s: got res=%h we=%b dz=%b expected res=%h we=%b dz=%b",
               req, r, w, z, er, ew, ez);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one rising edge between).
  task automatic run_op(string req, logic [4:0] op, logic [15:0] a, logic [15:0] b,
                        logic [15:0] er, logic ew, logic ez);
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    check(req, res_q, wr_en_q, div_zero_q, er, ew, ez);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 reset", res_q, wr_en_q, div_zero_q, 16'h0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_compare();
    run_op("R1 eq equal",     5'd4, 16'h8123, 16'h8123, 16'd1, 1'b1, 1'b0);
    run_op("R1 eq differ",    5'd4, 16'h8123, 16'h0123, 16'd0, 1'b1, 1'b0);
    run_op("R2 gt unsigned",  5'd5, 16'h8000, 16'h7FFF, 16'd1, 1'b1, 1'b0);
    run_op("R2 gt equal",     5'd5, 16'h1234, 16'h1234, 16'd0, 1'b1, 1'b0);
    run_op("R2 gt less",      5'd5, 16'h0001, 16'hFFFF, 16'd0, 1'b1, 1'b0);
  endtask

  task automatic t_arith();
    logic [31:0] p;
    run_op("R3 add plain",    5'd9, 16'd100, 16'd23, 16'd123, 1'b1, 1'b0);
    run_op("R3 add wrap",     5'd9, 16'h7FFF, 16'h0001, 16'h0000, 1'b1, 1'b0);
    run_op("R3 add wide",     5'd9, 16'hFFFF, 16'hFFFF, 16'h7FFE, 1'b1, 1'b0);
    p = 32'h1234 * 32'h5678;
    run_op("R4 mul mixed",    5'd10, 16'h1234, 16'h5678, {1'b0, p[14:0]}, 1'b1, 1'b0);
    run_op("R4 mul full",     5'd10, 16'hFFFF, 16'hFFFF, 16'h0001, 1'b1, 1'b0);
  endtask

  task automatic t_remainder();
    run_op("R5 rem",          5'd11, 16'd100, 16'd7, 16'd2, 1'b1, 1'b0);
    run_op("R5 rem big",      5'd11, 16'hFFFF, 16'h8000, 16'h7FFF, 1'b1, 1'b0);
    run_op("R6 rem by zero",  5'd11, 16'd5, 16'd0, 16'd0, 1'b1, 1'b1);
    run_op("R6 flag clears",  5'd9, 16'd1, 16'd0, 16'd1, 1'b1, 1'b0);
  endtask

  task automatic t_logic();
    run_op("R7 and",          5'd12, 16'hF0F0, 16'hFF00, 16'hF000, 1'b1, 1'b0);
    run_op("R7 or",           5'd13, 16'hF0F0, 16'h0F00, 16'hFFF0, 1'b1, 1'b0);
    run_op("R8 inv zero",     5'd14, 16'h0000, 16'hFFFF, 16'h7FFF, 1'b1, 1'b0);
    run_op("R8 inv top",      5'd14, 16'h8000, 16'h1234, 16'h7FFF, 1'b1, 1'b0);
    run_op("R8 inv b ignored",5'd14, 16'h1234, 16'h0000, 16'h6DCB, 1'b1, 1'b0);
  endtask

  task automatic t_bad_ops();
    run_op("R9 code 0",       5'd0, 16'h1111, 16'h2222, 16'h0, 1'b0, 1'b0);
    run_op("R9 code 21",      5'd21, 16'h1111, 16'h0000, 16'h0, 1'b0, 1'b0);
    run_op("R9 code 31",      5'd31, 16'hFFFF, 16'hFFFF, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    run_op("R10 setup",       5'd9, 16'd40, 16'd2, 16'd42, 1'b1, 1'b0);
    @(negedge clk);
    op_code = 5'd12; opnd_a = 16'h00FF; opnd_b = 16'h0F0F;
    #2;
    check("R10 hold before edge", res_q, wr_en_q, div_zero_q, 16'd42, 1'b1, 1'b0);
    @(negedge clk);
    check("R10 update after edge", res_q, wr_en_q, div_zero_q, 16'h000F, 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R10 sync reset", res_q, wr_en_q, div_zero_q, 16'h0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_compare();
    t_arith();
    t_remainder();
    t_logic();
    t_bad_ops();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule